// File: doc/BRIEF.md
# Receive FIFO Flow Delay RTS Control

This block generates the request-to-send line for a serial receiver with hardware flow control. It compares the current receive FIFO occupancy with a programmable 6-bit flow delay threshold. When occupancy reaches the threshold, an internal trigger is raised. While flow-control mode is on, the trigger latches a stop request that drives the active-low RTS pin to its inactive level. Software can read the trigger as a status bit. The trigger never raises an interrupt.

The stop request clears only after the FIFO has drained to four entries or more below the threshold, and only while the trigger is low. This band of hysteresis stops RTS from toggling when the level hovers near the threshold. A threshold below 4 switches the function off. In that case, as when flow-control mode is off, RTS simply follows a manual request bit. The FIFO, the interrupt logic and the register interface lie outside this block.

Top module: `rx_flow_rts`

## Requirements
- R1: While reset is high and in the cycle after it, `rts_n` is 1 and `trig_status` is 0.
- R2: One cycle after a sample with `fifo_level >= flow_thresh` and `flow_thresh >= 4`, `trig_status` is 1. In all other cases it is 0 one cycle later.
- R3: A threshold below 4 disables the function. One cycle later `trig_status` is 0 and `rts_n` equals the inverse of `rts_manual`.
- R4: With `flow_mode` at 0, `rts_n` one cycle later is the inverse of `rts_manual`, whatever the FIFO level is.
- R5: With `flow_mode` at 1 and the function enabled, a level at or above the threshold makes `rts_n` 1 one cycle later.
- R6: After a stop request, a level below the threshold but above threshold minus 4 keeps `rts_n` at 1.
- R7: A stopped channel resumes once `fifo_level + 4 <= flow_thresh`. One cycle later `rts_n` is again the inverse of `rts_manual`.
- R8: A FIFO level of 64 (the 7-bit level port at its full count) is compared without wrap and counts as at or above any threshold.
- R9: A trigger that occurred while `flow_mode` was 0 leaves no stop request behind. If flow mode is then turned on with the level inside the hysteresis band, RTS follows `rts_manual`.
- R10: Turning `flow_mode` off cancels a pending stop request. `rts_n` follows `rts_manual` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | 7 | Current receive FIFO occupancy, 0 to 64 |
| flow_thresh | input | 6 | Flow delay threshold. A value below 4 disables the function |
| flow_mode | input | 1 | Hardware flow-control mode enable |
| rts_manual | input | 1 | Manual request-to-send bit, 1 = request |
| rts_n | output | 1 | Active-low RTS pin, registered |
| trig_status | output | 1 | Readable flow delay trigger status, registered |

## Verification
Both outputs are registered directly from the sampled inputs. Each result is therefore due exactly one clock edge after the inputs that cause it, and the stop request adds no extra cycle. The bench changes the inputs 1 ns after a rising edge and samples both outputs 1 ns after the following edge. It checks each sample against a model that was advanced at that same edge. The sweeps cover every threshold and both mode and manual settings, ramping the level up to 64 and back down. Directed sequences cover the mode-change cases.

// File: rtl/flowdel_pkg.sv
package flowdel_pkg;
  // Result of comparing FIFO level with the flow delay threshold
  typedef struct packed {
    logic enabled;   // threshold large enough to enable the function
    logic trig;      // level has reached the threshold
    logic drained;   // level at or below threshold minus hysteresis
  } cmp_res_t;
endpackage

// File: rtl/flowdel_cmp.sv
module flowdel_cmp
  import flowdel_pkg::*;
#(
  parameter int THR_W   = 6,
  parameter int HYST    = 4,
  parameter int MIN_THR = 4,
  localparam int LVL_W  = THR_W + 1,
  localparam int CMP_W  = LVL_W + 1
) (
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr,
  output cmp_res_t         res
);
  logic [CMP_W-1:0] lvl_x;
  logic [CMP_W-1:0] thr_x;

  // Widen both so a full FIFO plus hysteresis never wraps
  assign lvl_x = {1'b0, level};
  assign thr_x = {2'b00, thr};

  always_comb begin
    res.enabled = (thr_x >= CMP_W'(MIN_THR));
    res.trig    = res.enabled && (lvl_x >= thr_x);
    res.drained = ((lvl_x + CMP_W'(HYST)) <= thr_x);
  end
endmodule

// File: rtl/flowdel_stop.sv
module flowdel_stop (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic trig,
  input  logic drained,
  output logic stop_next,
  output logic stop_q
);
  always_comb begin
    if (!active)      stop_next = 1'b0;
    else if (trig)    stop_next = 1'b1;
    else if (drained) stop_next = 1'b0;
    else              stop_next = stop_q;
  end

  always_ff @(posedge clk) begin
    if (rst) stop_q <= 1'b0;
    else     stop_q <= stop_next;
  end

  // R5
  stop_set_chk: assert property (@(posedge clk) disable iff (rst)
    (active && trig) |=> stop_q);
  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !trig && !drained) |=> $stable(stop_q));
  // R7
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !trig && drained) |=> !stop_q);
endmodule

// File: rtl/flowdel_out.sv
module flowdel_out (
  input  logic clk,
  input  logic rst,
  input  logic manual,
  input  logic stop_next,
  input  logic trig,
  output logic rts_n,
  output logic trig_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n  <= 1'b1;
      trig_q <= 1'b0;
    end else begin
      rts_n  <= ~(manual & ~stop_next);
      trig_q <= trig;
    end
  end

  // R5
  stop_blocks_rts_chk: assert property (@(posedge clk) disable iff (rst)
    stop_next |=> rts_n);
endmodule

// File: rtl/rx_flow_rts.sv
module rx_flow_rts
  import flowdel_pkg::*;
#(
  parameter int THR_W   = 6,
  parameter int HYST    = 4,
  parameter int MIN_THR = 4,
  localparam int LVL_W  = THR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [THR_W-1:0] flow_thresh,
  input  logic             flow_mode,
  input  logic             rts_manual,
  output logic             rts_n,
  output logic             trig_status
);
  cmp_res_t res;
  logic     active;
  logic     stop_next;
  logic     stop_q;

  flowdel_cmp #(.THR_W(THR_W), .HYST(HYST), .MIN_THR(MIN_THR)) u_cmp (
    .level (fifo_level),
    .thr   (flow_thresh),
    .res   (res)
  );

  assign active = flow_mode & res.enabled;

  flowdel_stop u_stop (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .trig      (res.trig),
    .drained   (res.drained),
    .stop_next (stop_next),
    .stop_q    (stop_q)
  );

  flowdel_out u_out (
    .clk       (clk),
    .rst       (rst),
    .manual    (rts_manual),
    .stop_next (stop_next),
    .trig      (res.trig),
    .rts_n     (rts_n),
    .trig_q    (trig_status)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rts_n && !trig_status));
  // R3
  disabled_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (flow_thresh < THR_W'(MIN_THR)) |=> !trig_status);
  // R4
  manual_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !flow_mode |=> (rts_n == !$past(rts_manual)));
  // R8
  full_level_chk: assert property (@(posedge clk) disable iff (rst)
    ((fifo_level == LVL_W'(1 << THR_W)) && (flow_thresh >= THR_W'(MIN_THR)))
      |=> trig_status);
  // R10
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!flow_mode && rts_manual) |=> (!rts_n && !stop_q));
endmodule

// File: tb/test_rx_flow_rts.sv
module test_rx_flow_rts;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] fifo_level = '0;
  logic [5:0] flow_thresh = '0;
  logic       flow_mode = 1'b0;
  logic       rts_manual = 1'b0;
  logic       rts_n;
  logic       trig_status;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  bit  m_stop = 1'b0;

  always #5 clk = ~clk;

  rx_flow_rts i_rx_flow_rts (
    .clk(clk), .rst(rst), .fifo_level(fifo_level), .flow_thresh(flow_thresh),
    .flow_mode(flow_mode), .rts_manual(rts_manual),
    .rts_n(rts_n), .trig_status(trig_status)
  );

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b (lvl=%0d thr=%0d mode=%0b man=%0b)",
               tag, what, got, exp, fifo_level, flow_thresh, flow_mode, rts_manual);
    end
  endtask

  // Drive one sample, advance the model, check 1 ns after the edge
  task automatic step(input int lvl, input int thr, input bit fl, input bit man, input string tag_override);
    bit en, trig, drained, prev;
    string ttag, rtag;
    fifo_level = 7'(lvl); flow_thresh = 6'(thr); flow_mode = fl; rts_manual = man;
    en      = (thr >= 4);
    trig    = en && (lvl >= thr);
    drained = (lvl + 4 <= thr);
    prev    = m_stop;
    if (!(fl && en))   m_stop = 1'b0;
    else if (trig)     m_stop = 1'b1;
    else if (drained)  m_stop = 1'b0;
    ttag = (lvl == 64) ? "R8" : (thr < 4) ? "R3" : "R2";
    if (!fl)            rtag = "R4";
    else if (thr < 4)   rtag = "R3";
    else if (trig)      rtag = "R5";
    else if (prev && !drained) rtag = "R6";
    else                rtag = "R7";
    if (tag_override != "") rtag = tag_override;
    @(posedge clk);
    #1;
    chk(trig_status, trig, ttag, "trig_status");
    chk(rts_n, !(man && !m_stop), rtag, "rts_n");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rts_n, 1'b1, "R1", "rts_n in reset");
    chk(trig_status, 1'b0, "R1", "trig_status in reset");
    rts_manual = 1'b1;
    fifo_level = 7'd64; flow_thresh = 6'd10;
    rst = 1'b0;
    // first edge after release already uses the inputs; checked below by model
    m_stop = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    chk(rts_n, 1'b1, "R1", "rts_n after reset edge");
    chk(trig_status, 1'b0, "R1", "trig_status after reset edge");

    // Sweep every threshold, both modes, both manual values
    for (int thr = 0; thr < 64; thr++)
      for (int fl = 0; fl < 2; fl++)
        for (int man = 0; man < 2; man++) begin
          for (int l = 0; l <= 64; l++) step(l, thr, fl[0], man[0], "");
          for (int l = 64; l >= 0; l--) step(l, thr, fl[0], man[0], "");
        end

    // R9: trigger seen with mode off, then mode on inside the band
    step(0, 20, 1'b0, 1'b1, "R9");
    step(30, 20, 1'b0, 1'b1, "R9");
    step(18, 20, 1'b0, 1'b1, "R9");
    step(18, 20, 1'b1, 1'b1, "R9");
    chk(rts_n, 1'b0, "R9", "rts_n with no latched stop");

    // R10: stop pending, mode switched off in the band
    step(25, 20, 1'b1, 1'b1, "R5");
    step(18, 20, 1'b1, 1'b1, "R6");
    step(18, 20, 1'b0, 1'b1, "R10");
    chk(rts_n, 1'b0, "R10", "rts_n after mode off");
    step(18, 20, 1'b1, 1'b1, "R10");
    chk(rts_n, 1'b0, "R10", "stop not restored on mode on");

    // R7 boundary: level exactly threshold minus 4
    step(40, 40, 1'b1, 1'b1, "R5");
    step(37, 40, 1'b1, 1'b1, "R6");
    chk(rts_n, 1'b1, "R6", "band hold at thr-3");
    step(36, 40, 1'b1, 1'b1, "R7");
    chk(rts_n, 1'b0, "R7", "resume at thr-4");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule